// File: doc/BRIEF.md
# Flash Command Launch Controller

This block is the register front end that software uses to assemble a non-volatile memory command and hand it to a back-end command engine. Software sets a clock divider value, picks one of six 16-bit parameter slots through an index register, fills the slots through a data window, and then writes 1 to the command-complete flag in the status register to launch the command. At launch the controller copies the slots to the engine and pulses a start signal. The engine later returns a done pulse with per-slot result write enables. The results land back in the same slots for software to read.

A launch is refused when an error flag is still set. A program or erase command is also refused, and the access-error flag is raised, if the divider register has not been written since reset. While a command is in flight the complete flag reads 0 and software writes to the parameter slots have no effect.

Top module: `flash_cmd_launch`

Register map (2-bit address, 16-bit data): 0 = divider (bits 7:0 value, bit 15 read-only divider-loaded flag); 1 = slot index (bits 2:0); 2 = slot data window; 3 = status (bit 7 command complete, bit 5 access error, bit 4 protection violation; all three are write-1 bits).

## Requirements
- R1: After reset the status register reads 0x0080 (complete = 1, both error flags = 0), the divider register reads 0x0000, the index is 0, every slot reads 0 and the start output is 0.
- R2: Any write to the divider register (address 0) stores bits 7:0 and sets bit 15 of its readback. Bit 15 stays 1 after later writes, whatever the written data, until reset.
- R3: The index register (address 1, bits 2:0) selects which slot the data window (address 2) reads and writes. Index values 6 and 7 read as 0 and ignore writes.
- R4: Writing status bit 7 = 1 while complete = 1 and both error flags are 0 launches the command. The complete flag reads 0 from the next cycle, `eng_start` is high for exactly one cycle, and `eng_params` carries the slot contents captured at the launch (slot k in bits 16k+15:16k).
- R5: If slot 0 bit 15 is 1 (a program/erase opcode) and the divider-loaded flag is 0, a launch attempt does not start the engine. Instead it sets the access-error flag (status bit 5) and leaves complete at 1.
- R6: An opcode with slot 0 bit 15 = 0 launches even when the divider-loaded flag is 0.
- R7: While either error flag is set, writing status bit 7 = 1 does not pulse `eng_start` and leaves complete at 1.
- R8: The error flags clear only when 1 is written to their own status bits. Writing 0 to them leaves them unchanged.
- R9: While complete is 0, writes to the data window leave every slot unchanged.
- R10: An `eng_done` pulse while a command is in flight sets complete to 1 on that edge. It replaces each slot whose `eng_res_we` bit is 1 with the matching word of `eng_res_data`, keeps the other slots, and sets the protection-violation flag (status bit 4) if `eng_pviol` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the addressed register (combinational) |
| eng_start | output | 1 | One-cycle command start pulse to the engine |
| eng_params | output | 96 | Parameter slots captured at launch, slot k in bits 16k+15:16k |
| eng_done | input | 1 | Engine completion pulse |
| eng_res_we | input | 6 | Per-slot result write enables, valid with eng_done |
| eng_res_data | input | 96 | Result words, slot k in bits 16k+15:16k |
| eng_pviol | input | 1 | Engine reports a protection violation, valid with eng_done |

## Verification
A wrong complete flag shows up at once in the status readback. It also shows at `eng_start`, either as a missing pulse or as a pulse that lasts more than one cycle, in the cycle right after the write that should or should not launch. Corrupted slot contents appear in the window readback, or in `eng_params` one cycle after launch. A divider-loaded flag that is lost or was never set shows only when a program/erase launch is tried, as a spurious or missing access error. For that reason the bench tries such a launch both before and after the divider has been written.

// File: rtl/fcl_pkg.sv
package fcl_pkg;

    localparam int DATA_W      = 16;
    localparam int ADDR_W      = 2;
    localparam int SLOTS_DEF   = 6;
    localparam int IDX_W_DEF   = 3;
    localparam int DIV_W_DEF   = 8;

    // status bit positions (software-visible)
    localparam int ST_CMP_BIT  = 7;
    localparam int ST_ACC_BIT  = 5;
    localparam int ST_PV_BIT   = 4;
    // divider readback loaded flag
    localparam int DIV_LD_BIT  = 15;
    // opcode class bit inside slot 0
    localparam int OPC_PE_BIT  = 15;

    typedef enum logic [ADDR_W-1:0] {
        REG_DIV  = 2'd0,
        REG_IDX  = 2'd1,
        REG_WIN  = 2'd2,
        REG_STAT = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic cmp;
        logic acc;
        logic pv;
    } stat_t;

    typedef struct packed {
        logic div_we;
        logic idx_we;
        logic win_we;
        logic stat_we;
    } wr_dec_t;

    typedef struct packed {
        logic cmp_w1;
        logic acc_w1;
        logic pv_w1;
    } stat_wr_t;

    function automatic wr_dec_t decode_wr(input logic wr, input logic [ADDR_W-1:0] addr);
        wr_dec_t d;
        d.div_we  = wr && (addr == REG_DIV);
        d.idx_we  = wr && (addr == REG_IDX);
        d.win_we  = wr && (addr == REG_WIN);
        d.stat_we = wr && (addr == REG_STAT);
        return d;
    endfunction

    function automatic stat_wr_t stat_bits(input logic [DATA_W-1:0] w);
        stat_wr_t s;
        s.cmp_w1 = w[ST_CMP_BIT];
        s.acc_w1 = w[ST_ACC_BIT];
        s.pv_w1  = w[ST_PV_BIT];
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] stat_word(input stat_t s);
        logic [DATA_W-1:0] w;
        w = '0;
        w[ST_CMP_BIT] = s.cmp;
        w[ST_ACC_BIT] = s.acc;
        w[ST_PV_BIT]  = s.pv;
        return w;
    endfunction

    function automatic logic is_prog_erase(input logic [DATA_W-1:0] slot0);
        return slot0[OPC_PE_BIT];
    endfunction

endpackage

// File: rtl/fcl_div_reg.sv
module fcl_div_reg
    import fcl_pkg::*;
#(
    parameter int DIV_W = DIV_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [DIV_W-1:0] wdata,
    output logic [DIV_W-1:0] div_val,
    output logic             div_loaded
);

    always_ff @(posedge clk) begin
        if (rst) begin
            div_val    <= '0;
            div_loaded <= 1'b0;
        end else if (wr_en) begin
            div_val    <= wdata;
            div_loaded <= 1'b1;
        end
    end

    // R2
    div_loaded_set_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> div_loaded);

    // R2
    div_loaded_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        div_loaded |=> div_loaded);

endmodule

// File: rtl/fcl_slot_bank.sv
module fcl_slot_bank
    import fcl_pkg::*;
#(
    parameter int NUM_SLOTS = SLOTS_DEF,
    parameter int IDX_W     = IDX_W_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        idx_we,
    input  logic                        win_we,
    input  logic [DATA_W-1:0]           wdata,
    input  logic                        busy,
    input  logic                        res_done,
    input  logic [NUM_SLOTS-1:0]        res_we,
    input  logic [NUM_SLOTS*DATA_W-1:0] res_data,
    output logic [IDX_W-1:0]            idx_q,
    output logic [DATA_W-1:0]           win_rdata,
    output logic [NUM_SLOTS*DATA_W-1:0] slots_flat
);

    logic [DATA_W-1:0] slot_q [NUM_SLOTS];
    logic              sw_write;

    assign sw_write = win_we && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_q <= '0;
        end else if (idx_we) begin
            idx_q <= wdata[IDX_W-1:0];
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        logic hit;
        assign hit = (idx_q == IDX_W'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                slot_q[g] <= '0;
            end else if (res_done && res_we[g]) begin
                slot_q[g] <= res_data[g*DATA_W +: DATA_W];
            end else if (sw_write && hit) begin
                slot_q[g] <= wdata;
            end
        end

        assign slots_flat[g*DATA_W +: DATA_W] = slot_q[g];
    end

    always_comb begin
        win_rdata = '0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (idx_q == IDX_W'(i)) win_rdata = slot_q[i];
        end
    end

    // R9
    locked_slots_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && win_we && !res_done) |=> $stable(slots_flat));

    // R3
    oob_write_chk: assert property (@(posedge clk) disable iff (rst)
        (win_we && !res_done && (int'(idx_q) >= NUM_SLOTS)) |=> $stable(slots_flat));

endmodule

// File: rtl/fcl_launch_ctrl.sv
module fcl_launch_ctrl
    import fcl_pkg::*;
#(
    parameter int NUM_SLOTS = SLOTS_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        stat_we,
    input  stat_wr_t                    stat_w,
    input  logic                        opc_pe,
    input  logic                        div_loaded,
    input  logic [NUM_SLOTS*DATA_W-1:0] slots_flat,
    input  logic                        eng_done,
    input  logic                        eng_pviol,
    output stat_t                       stat_q,
    output logic                        eng_start,
    output logic [NUM_SLOTS*DATA_W-1:0] eng_params,
    output logic                        res_done
);

    logic launch_req;
    logic err_any;
    logic pe_block;
    logic go;
    logic reject;

    assign err_any    = stat_q.acc || stat_q.pv;
    assign launch_req = stat_we && stat_w.cmp_w1 && stat_q.cmp;
    assign pe_block   = opc_pe && !div_loaded;
    assign go         = launch_req && !err_any && !pe_block;
    assign reject     = launch_req && !err_any && pe_block;
    assign res_done   = eng_done && !stat_q.cmp;

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q.cmp <= 1'b1;
            stat_q.acc <= 1'b0;
            stat_q.pv  <= 1'b0;
            eng_start  <= 1'b0;
            eng_params <= '0;
        end else begin
            eng_start <= go;
            if (go) begin
                eng_params <= slots_flat;
                stat_q.cmp <= 1'b0;
            end else if (res_done) begin
                stat_q.cmp <= 1'b1;
            end

            if (reject) begin
                stat_q.acc <= 1'b1;
            end else if (stat_we && stat_w.acc_w1) begin
                stat_q.acc <= 1'b0;
            end

            if (res_done && eng_pviol) begin
                stat_q.pv <= 1'b1;
            end else if (stat_we && stat_w.pv_w1) begin
                stat_q.pv <= 1'b0;
            end
        end
    end

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |=> !eng_start);

    // R4
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start |-> !stat_q.cmp);

    // R5
    pe_reject_chk: assert property (@(posedge clk) disable iff (rst)
        (launch_req && !err_any && opc_pe && !div_loaded) |=> (stat_q.acc && stat_q.cmp && !eng_start));

    // R7
    err_block_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_we && stat_w.cmp_w1 && (stat_q.acc || stat_q.pv)) |=> (!eng_start && stat_q.cmp));

    // R10
    done_cmp_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !stat_q.cmp) |=> stat_q.cmp);

    // R8
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (stat_q.acc && !(stat_we && stat_w.acc_w1)) |=> stat_q.acc);

endmodule

// File: rtl/flash_cmd_launch.sv
module flash_cmd_launch
    import fcl_pkg::*;
#(
    parameter int NUM_SLOTS = SLOTS_DEF,
    parameter int IDX_W     = IDX_W_DEF,
    parameter int DIV_W     = DIV_W_DEF
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [DATA_W-1:0]           bus_wdata,
    output logic [DATA_W-1:0]           bus_rdata,
    output logic                        eng_start,
    output logic [NUM_SLOTS*DATA_W-1:0] eng_params,
    input  logic                        eng_done,
    input  logic [NUM_SLOTS-1:0]        eng_res_we,
    input  logic [NUM_SLOTS*DATA_W-1:0] eng_res_data,
    input  logic                        eng_pviol
);

    localparam int DIV_PAD = DATA_W - 1 - DIV_W;
    localparam int IDX_PAD = DATA_W - IDX_W;

    wr_dec_t                     dec;
    logic [DIV_W-1:0]            div_val;
    logic                        div_loaded;
    logic [IDX_W-1:0]            idx_q;
    logic [DATA_W-1:0]           win_rdata;
    logic [NUM_SLOTS*DATA_W-1:0] slots_flat;
    stat_t                       stat_q;
    logic                        res_done;

    assign dec = decode_wr(bus_wr, bus_addr);

    fcl_div_reg #(.DIV_W(DIV_W)) u_div (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (dec.div_we),
        .wdata      (bus_wdata[DIV_W-1:0]),
        .div_val    (div_val),
        .div_loaded (div_loaded)
    );

    fcl_slot_bank #(.NUM_SLOTS(NUM_SLOTS), .IDX_W(IDX_W)) u_slots (
        .clk        (clk),
        .rst        (rst),
        .idx_we     (dec.idx_we),
        .win_we     (dec.win_we),
        .wdata      (bus_wdata),
        .busy       (!stat_q.cmp),
        .res_done   (res_done),
        .res_we     (eng_res_we),
        .res_data   (eng_res_data),
        .idx_q      (idx_q),
        .win_rdata  (win_rdata),
        .slots_flat (slots_flat)
    );

    fcl_launch_ctrl #(.NUM_SLOTS(NUM_SLOTS)) u_launch (
        .clk        (clk),
        .rst        (rst),
        .stat_we    (dec.stat_we),
        .stat_w     (stat_bits(bus_wdata)),
        .opc_pe     (is_prog_erase(slots_flat[DATA_W-1:0])),
        .div_loaded (div_loaded),
        .slots_flat (slots_flat),
        .eng_done   (eng_done),
        .eng_pviol  (eng_pviol),
        .stat_q     (stat_q),
        .eng_start  (eng_start),
        .eng_params (eng_params),
        .res_done   (res_done)
    );

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            REG_DIV:  bus_rdata = {div_loaded, {DIV_PAD{1'b0}}, div_val};
            REG_IDX:  bus_rdata = {{IDX_PAD{1'b0}}, idx_q};
            REG_WIN:  bus_rdata = win_rdata;
            default:  bus_rdata = stat_word(stat_q);
        endcase
    end

    // R10
    done_pv_chk: assert property (@(posedge clk) disable iff (rst)
        (eng_done && !stat_q.cmp && eng_pviol) |=> stat_q.pv);

    // R6
    nonpe_go_chk: assert property (@(posedge clk) disable iff (rst)
        (dec.stat_we && bus_wdata[ST_CMP_BIT] && stat_q.cmp && !stat_q.acc && !stat_q.pv
         && !slots_flat[OPC_PE_BIT]) |=> eng_start);

endmodule

// File: tb/flash_cmd_launch_bench.sv
module flash_cmd_launch_bench;
    import fcl_pkg::*;

    localparam int NS = 6;

    typedef struct {
        string       req;
        int          sel;   // 0 = bus_rdata, 1 = eng_start, 2 = eng_params word
        int          word;
        logic [15:0] exp;
    } item_t;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               bus_wr = 1'b0;
    logic [1:0]         bus_addr = '0;
    logic [15:0]        bus_wdata = '0;
    logic [15:0]        bus_rdata;
    logic               eng_start;
    logic [NS*16-1:0]   eng_params;
    logic               eng_done = 1'b0;
    logic [NS-1:0]      eng_res_we = '0;
    logic [NS*16-1:0]   eng_res_data = '0;
    logic               eng_pviol = 1'b0;

    item_t q[$];
    logic  strobe = 1'b0;
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    finished = 1'b0;

    always #2.5 clk = ~clk;

    flash_cmd_launch u_flash_cmd_launch (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_start(eng_start),
        .eng_params(eng_params), .eng_done(eng_done), .eng_res_we(eng_res_we),
        .eng_res_data(eng_res_data), .eng_pviol(eng_pviol)
    );

    // monitor: pops expected items and compares mid-cycle
    always @(negedge clk) begin
        if (strobe && q.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it = q.pop_front();
            case (it.sel)
                0:       act = bus_rdata;
                1:       act = {15'd0, eng_start};
                default: act = eng_params[it.word*16 +: 16];
            endcase
            n_cmp++;
            if (act !== it.exp) begin
                n_bad++;
                $display("FAIL %s: actual 0x%04h expected 0x%04h", it.req, act, it.exp);
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic expect_item(input string req, input int sel, input int word,
                               input logic [1:0] a, input logic [15:0] e);
        item_t it;
        it.req = req; it.sel = sel; it.word = word; it.exp = e;
        q.push_back(it);
        bus_addr = a;
        strobe = 1'b1;
        tick();
        strobe = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] a, input logic [15:0] e);
        expect_item(req, 0, 0, a, e);
    endtask

    task automatic slot_rd(input string req, input int idx, input logic [15:0] e);
        wr(2'd1, 16'(idx));
        rd(req, 2'd2, e);
    endtask

    task automatic slot_wr(input int idx, input logic [15:0] d);
        wr(2'd1, 16'(idx));
        wr(2'd2, d);
    endtask

    task automatic done(input logic [NS-1:0] we, input logic [NS*16-1:0] dat, input logic pv);
        eng_done = 1'b1; eng_res_we = we; eng_res_data = dat; eng_pviol = pv;
        tick();
        eng_done = 1'b0; eng_res_we = '0; eng_pviol = 1'b0;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) tick();
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        do_reset();
        // R1 reset state
        rd("R1 status", 2'd3, 16'h0080);
        rd("R1 divider", 2'd0, 16'h0000);
        rd("R1 index", 2'd1, 16'h0000);
        rd("R1 slot0", 2'd2, 16'h0000);
        expect_item("R1 start", 1, 0, 2'd3, 16'h0000);

        // R3 indexed window
        slot_wr(1, 16'h1234);
        slot_wr(5, 16'hBEEF);
        slot_wr(6, 16'hFFFF);
        slot_rd("R3 idx6 reads zero", 6, 16'h0000);
        slot_rd("R3 slot1", 1, 16'h1234);
        slot_rd("R3 slot5", 5, 16'hBEEF);

        // R5 program/erase opcode without divider
        slot_wr(0, 16'h8000);
        wr(2'd3, 16'h0080);
        expect_item("R5 no start", 1, 0, 2'd3, 16'h0000);
        rd("R5 acc set cmp kept", 2'd3, 16'h00A0);
        // R7 error blocks launch
        wr(2'd3, 16'h0080);
        expect_item("R7 no start acc", 1, 0, 2'd3, 16'h0000);
        rd("R7 status kept", 2'd3, 16'h00A0);
        // R8 write-1-to-clear
        wr(2'd3, 16'h0000);
        rd("R8 zero write keeps acc", 2'd3, 16'h00A0);
        wr(2'd3, 16'h0020);
        rd("R8 acc cleared", 2'd3, 16'h0080);

        // R2 divider
        wr(2'd0, 16'h0013);
        rd("R2 loaded and value", 2'd0, 16'h8013);
        wr(2'd0, 16'h0000);
        rd("R2 loaded sticky", 2'd0, 16'h8000);

        // R4 launch
        wr(2'd3, 16'h0080);
        expect_item("R4 start pulse", 1, 0, 2'd3, 16'h0001);
        expect_item("R4 start one cycle", 1, 0, 2'd3, 16'h0000);
        rd("R4 cmp low", 2'd3, 16'h0000);
        expect_item("R4 params word0", 2, 0, 2'd3, 16'h8000);
        expect_item("R4 params word1", 2, 1, 2'd3, 16'h1234);
        expect_item("R4 params word5", 2, 5, 2'd3, 16'hBEEF);

        // R9 writes locked while busy
        slot_wr(1, 16'h5555);
        slot_rd("R9 slot1 unchanged", 1, 16'h1234);

        // R10 completion with results
        done(6'b000010, {16'h0, 16'h0, 16'h0, 16'h0, 16'hAAAA, 16'h7777}, 1'b1);
        rd("R10 cmp set pv set", 2'd3, 16'h0090);
        slot_rd("R10 slot1 result", 1, 16'hAAAA);
        slot_rd("R10 slot0 kept", 0, 16'h8000);

        // R7 protection violation blocks launch
        wr(2'd3, 16'h0080);
        expect_item("R7 no start pv", 1, 0, 2'd3, 16'h0000);
        rd("R7 status pv", 2'd3, 16'h0090);
        wr(2'd3, 16'h0010);
        rd("R8 pv cleared", 2'd3, 16'h0080);

        // R6 non program/erase opcode without divider
        do_reset();
        slot_wr(0, 16'h1200);
        wr(2'd3, 16'h0080);
        expect_item("R6 start pulse", 1, 0, 2'd3, 16'h0001);
        rd("R6 busy", 2'd3, 16'h0000);
        done(6'b000000, '0, 1'b0);
        rd("R10 cmp back", 2'd3, 16'h0080);
        slot_rd("R10 slot0 untouched", 0, 16'h1200);

        tick();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule